// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Plane

This block is the logic core of a small field-configurable logic device, written as synthesizable logic. Ten dedicated inputs and eight feedback signals each drive two array lines: one true and one inverted. That gives 36 lines. A stored connection map of 113 rows, each 36 bits wide, picks which lines feed each product term. Each product term is the AND of the lines connected to it.

Most rows feed eight OR sums of unequal size. The remaining rows act as control terms: one output-enable term per output, plus a preset term, a clear term and a clock term, all taken from the same array. The output registers and pin drivers that consume these terms live outside this block.

The map is loaded one row per cycle through a write strobe, a row address and a 36-bit data word. A single-cycle erase strobe opens every connection. All outputs are combinational functions of the live inputs and the stored map.

Top module: `sop_logic_array`

## Requirements
- R1: Signal k drives line 2k with its true value and line 2k+1 with its inverse. Signals 0..9 are `ded_in[9:0]` and signals 10..17 are `fb_in[7:0]`. A row bit of 1 connects that line, and a product term is the AND of its connected lines.
- R2: A row with no connections (all zeros) evaluates to 1 for every input pattern.
- R3: A row that connects both the true and the inverted line of the same signal evaluates to 0 for every input pattern, and so adds nothing to its sum.
- R4: Rows 0..101 feed the sums in ascending order, with group sizes 8, 10, 12, 16, 16, 16, 14 and 10 for outputs 0 to 7. `sum_out[j]` is the OR of its group.
- R5: Rows 102..109 drive `oe_term[0]`..`oe_term[7]` directly.
- R6: Row 110 drives `preset_term`, row 111 drives `clear_term` and row 112 drives `clock_term`.
- R7: When `cfg_wr` is high at a rising clock edge, `cfg_bits` is stored into row `cfg_row`, and the outputs use the new row from the next cycle on. With no strobe, the map holds its contents.
- R8: When `cfg_erase` is high at a rising clock edge, every row is cleared in that one cycle. Erase takes priority over a write in the same cycle.
- R9: A write to a row address of 113 or above changes no row.
- R10: The synchronous active-high `rst` clears every row, so after reset all outputs are 1.
- R11: The outputs follow changes on `ded_in` and `fb_in` within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the connection map |
| rst | input | 1 | Synchronous active-high reset; clears the map |
| cfg_erase | input | 1 | Clears every row in one cycle |
| cfg_wr | input | 1 | Row write strobe |
| cfg_row | input | 7 | Row address for a write |
| cfg_bits | input | 36 | Connection bits for the addressed row |
| ded_in | input | 10 | Dedicated logic inputs |
| fb_in | input | 8 | Feedback or I/O inputs |
| sum_out | output | 8 | OR of each output's product-term group |
| oe_term | output | 8 | Per-output enable product terms |
| preset_term | output | 1 | Global preset product term |
| clear_term | output | 1 | Global clear product term |
| clock_term | output | 1 | Clock product term |

## Verification
The bench targets the boundaries of the unequal groups: the first row of output 0, the last row of output 1, the first row of output 3 and the last sum row, 101. A design with a wrong group offset would move a term into the neighbouring output. Contradictory rows must read 0 and empty rows must read 1; swapping these two rules would turn all the killed outputs high. Other cases checked are an erase in the same cycle as a write (a wrong priority would leave row 0 programmed), out-of-range row addresses (a missing bounds check could corrupt a row), and a reset in the middle of a run. Random inputs combined with random writes are compared on every cycle against a behavioural model that evaluates each row line by line.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int N_DED  = 10;
    localparam int N_FB   = 8;
    localparam int N_SIG  = N_DED + N_FB;
    localparam int N_LINE = 2 * N_SIG;
    localparam int N_OUT  = 8;

    // product terms per OR sum, output 0 first
    localparam int GRP_SIZE [N_OUT] = '{8, 10, 12, 16, 16, 16, 14, 10};

    function automatic int grp_base(int j);
        int acc;
        acc = 0;
        for (int i = 0; i < j; i++) acc += GRP_SIZE[i];
        return acc;
    endfunction

    localparam int N_SUM_TERM = grp_base(N_OUT);
    localparam int ROW_OE     = N_SUM_TERM;
    localparam int ROW_PRESET = ROW_OE + N_OUT;
    localparam int ROW_CLEAR  = ROW_PRESET + 1;
    localparam int ROW_CLOCK  = ROW_CLEAR + 1;
    localparam int N_ROW      = ROW_CLOCK + 1;
    localparam int ROW_AW     = $clog2(N_ROW);

    typedef logic [N_LINE-1:0] row_t;

    typedef struct packed {
        logic              erase;
        logic              wr;
        logic [ROW_AW-1:0] row;
        row_t              bits;
    } cfg_req_t;

    typedef struct packed {
        logic [N_OUT-1:0] oe;
        logic             preset;
        logic             clear;
        logic             clock;
    } ctl_t;

endpackage

// File: rtl/sop_row_store.sv
module sop_row_store
    import sop_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  cfg_req_t                      req,
    output logic [N_ROW-1:0][N_LINE-1:0]  rows_q
);

    logic row_ok;
    assign row_ok = int'(req.row) < N_ROW;

    always_ff @(posedge clk) begin
        if (rst || req.erase) begin
            rows_q <= '0;
        end else if (req.wr && row_ok) begin
            rows_q[req.row] <= req.bits;
        end
    end

endmodule

// File: rtl/sop_term_eval.sv
module sop_term_eval
    import sop_pkg::*;
(
    input  logic [N_DED-1:0]              ded_in,
    input  logic [N_FB-1:0]               fb_in,
    input  logic [N_ROW-1:0][N_LINE-1:0]  rows_q,
    output logic [N_ROW-1:0]              term_vec
);

    logic [N_SIG-1:0]  sig;
    logic [N_LINE-1:0] lines;

    assign sig = {fb_in, ded_in};

    for (genvar k = 0; k < N_SIG; k++) begin : g_line
        assign lines[2*k]   = sig[k];
        assign lines[2*k+1] = ~sig[k];
    end

    // an open connection forces its AND input high
    for (genvar r = 0; r < N_ROW; r++) begin : g_term
        assign term_vec[r] = &(lines | ~rows_q[r]);
    end

endmodule

// File: rtl/sop_sum_collect.sv
module sop_sum_collect
    import sop_pkg::*;
(
    input  logic [N_ROW-1:0] term_vec,
    output logic [N_OUT-1:0] sum_out,
    output ctl_t             ctl
);

    logic [N_OUT-1:0] oe_vec;

    for (genvar j = 0; j < N_OUT; j++) begin : g_or
        localparam int BASE = grp_base(j);
        localparam int SIZE = GRP_SIZE[j];
        assign sum_out[j] = |term_vec[BASE+SIZE-1:BASE];
        assign oe_vec[j]  = term_vec[ROW_OE+j];
    end

    assign ctl = '{oe:     oe_vec,
                   preset: term_vec[ROW_PRESET],
                   clear:  term_vec[ROW_CLEAR],
                   clock:  term_vec[ROW_CLOCK]};

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
    import sop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_erase,
    input  logic              cfg_wr,
    input  logic [ROW_AW-1:0] cfg_row,
    input  logic [N_LINE-1:0] cfg_bits,
    input  logic [N_DED-1:0]  ded_in,
    input  logic [N_FB-1:0]   fb_in,
    output logic [N_OUT-1:0]  sum_out,
    output logic [N_OUT-1:0]  oe_term,
    output logic              preset_term,
    output logic              clear_term,
    output logic              clock_term
);

    cfg_req_t                     req;
    logic [N_ROW-1:0][N_LINE-1:0] row_bits;
    logic [N_ROW-1:0]             term_vec;
    ctl_t                         ctl;

    assign req = '{erase: cfg_erase, wr: cfg_wr, row: cfg_row, bits: cfg_bits};

    sop_row_store u_store (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .rows_q (row_bits)
    );

    sop_term_eval u_eval (
        .ded_in   (ded_in),
        .fb_in    (fb_in),
        .rows_q   (row_bits),
        .term_vec (term_vec)
    );

    sop_sum_collect u_or (
        .term_vec (term_vec),
        .sum_out  (sum_out),
        .ctl      (ctl)
    );

    assign oe_term     = ctl.oe;
    assign preset_term = ctl.preset;
    assign clear_term  = ctl.clear;
    assign clock_term  = ctl.clock;

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk
    import sop_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         cfg_erase,
    input logic                         cfg_wr,
    input logic [ROW_AW-1:0]            cfg_row,
    input logic [N_LINE-1:0]            cfg_bits,
    input logic [N_OUT-1:0]             sum_out,
    input logic [N_OUT-1:0]             oe_term,
    input logic                         preset_term,
    input logic                         clear_term,
    input logic                         clock_term,
    input logic [N_ROW-1:0]             term_vec,
    input logic [N_ROW-1:0][N_LINE-1:0] row_bits
);

    logic in_range;
    assign in_range = int'(cfg_row) < N_ROW;

    assert_erase_opens_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_erase |=> (sum_out == '1 && oe_term == '1 && preset_term && clear_term && clock_term));

    assert_empty_row_true_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst && cfg_wr && !cfg_erase && in_range && cfg_bits == '0) |=> term_vec[$past(cfg_row)]);

    assert_dual_polarity_false_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && cfg_wr && !cfg_erase && in_range && cfg_bits[1:0] == 2'b11) |=> !term_vec[$past(cfg_row)]);

    assert_bad_row_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (!rst && cfg_wr && !cfg_erase && !in_range) |=> $stable(row_bits));

    assert_map_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (!rst && !cfg_wr && !cfg_erase) |=> $stable(row_bits));

    assert_row_written_R7: assert property (@(posedge clk) disable iff (rst)
        (!rst && cfg_wr && !cfg_erase && in_range) |=> row_bits[$past(cfg_row)] == $past(cfg_bits));

    assert_no_terms_no_out_R4: assert property (@(posedge clk) disable iff (rst)
        (term_vec == '0) |-> (sum_out == '0 && oe_term == '0 && !preset_term && !clear_term && !clock_term));

endmodule

bind sop_logic_array sop_array_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_erase   (cfg_erase),
    .cfg_wr      (cfg_wr),
    .cfg_row     (cfg_row),
    .cfg_bits    (cfg_bits),
    .sum_out     (sum_out),
    .oe_term     (oe_term),
    .preset_term (preset_term),
    .clear_term  (clear_term),
    .clock_term  (clock_term),
    .term_vec    (term_vec),
    .row_bits    (row_bits)
);

// File: tb/sop_logic_array_test.sv
`timescale 1ns/1ps
module sop_logic_array_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_erase = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [6:0]  cfg_row = '0;
    logic [35:0] cfg_bits = '0;
    logic [9:0]  ded_in = '0;
    logic [7:0]  fb_in = '0;
    logic [7:0]  sum_out, oe_term;
    logic        preset_term, clear_term, clock_term;

    always #2 clk = ~clk;

    sop_logic_array uut (
        .clk(clk), .rst(rst), .cfg_erase(cfg_erase), .cfg_wr(cfg_wr),
        .cfg_row(cfg_row), .cfg_bits(cfg_bits), .ded_in(ded_in), .fb_in(fb_in),
        .sum_out(sum_out), .oe_term(oe_term), .preset_term(preset_term),
        .clear_term(clear_term), .clock_term(clock_term)
    );

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;
    string phase = "R10";

    // behavioural reference
    bit [35:0] mdl [113];
    int sz [8] = '{8, 10, 12, 16, 16, 16, 14, 10};

    function automatic bit m_term(int r);
        for (int l = 0; l < 36; l++) begin
            int  s;
            bit  v;
            s = l / 2;
            v = (s < 10) ? ded_in[s] : fb_in[s-10];
            if (l % 2 == 1) v = !v;
            if (mdl[r][l] && !v) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit [7:0] m_sum();
        bit [7:0] res;
        int base;
        res = '0;
        base = 0;
        for (int j = 0; j < 8; j++) begin
            for (int t = 0; t < sz[j]; t++) if (m_term(base + t)) res[j] = 1'b1;
            base += sz[j];
        end
        return res;
    endfunction

    function automatic bit [7:0] m_oe();
        bit [7:0] res;
        for (int j = 0; j < 8; j++) res[j] = m_term(102 + j);
        return res;
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst || cfg_erase) begin
            for (int r = 0; r < 113; r++) mdl[r] = '0;
        end else if (cfg_wr && cfg_row < 7'd113) begin
            mdl[cfg_row] = cfg_bits;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (started && !done) begin
            chk(phase, "sum_out vs model", 32'(sum_out), 32'(m_sum()));
            chk(phase, "oe_term vs model", 32'(oe_term), 32'(m_oe()));
            chk(phase, "ctl vs model", {29'd0, preset_term, clear_term, clock_term},
                {29'd0, m_term(110), m_term(111), m_term(112)});
        end
    end

    task automatic wr_row(int r, logic [35:0] b);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_row = 7'(r); cfg_bits = b;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic set_in(logic [9:0] d, logic [7:0] f);
        @(posedge clk); #1;
        ded_in = d; fb_in = f;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        settle();
        // R10 / R2: empty map makes every term true
        chk("R10", "sum after reset", 32'(sum_out), 32'hFF);
        chk("R2", "oe after reset", 32'(oe_term), 32'hFF);
        set_in(10'h2A5, 8'h5A);
        settle();
        chk("R2", "ctl open rows", {29'd0, preset_term, clear_term, clock_term}, 32'd7);

        // R3: kill every row with a contradictory pair on signal 0
        phase = "R3";
        for (int r = 0; r < 113; r++) wr_row(r, 36'h3);
        settle();
        chk("R3", "sum all killed", 32'(sum_out), 32'h00);
        chk("R3", "oe all killed", 32'(oe_term), 32'h00);
        set_in(10'h3FF, 8'hFF);
        settle();
        chk("R3", "ctl all killed", {29'd0, preset_term, clear_term, clock_term}, 32'd0);

        // R1 R4 R5 R6: program rows at group edges and control rows
        phase = "R4";
        wr_row(0,   (36'd1 << 0) | (36'd1 << 25)); // ded0 & ~fb2
        wr_row(17,  36'd1 << 7);                   // ~ded3, last row of output 1
        wr_row(30,  36'd0);                        // open, first row of output 3
        wr_row(101, 36'd1 << 34);                  // fb7, last sum row
        wr_row(102, 36'd1 << 18);                  // oe0 = ded9
        wr_row(109, 36'd1 << 21);                  // oe7 = ~fb0
        wr_row(110, 36'd1 << 2);                   // preset = ded1
        wr_row(111, (36'd1 << 4) | (36'd1 << 8));  // clear = ded2 & ded4
        wr_row(112, 36'd1 << 31);                  // clock = ~fb5
        // R9: out-of-range rows must not disturb anything
        phase = "R9";
        wr_row(113, 36'd0);
        wr_row(127, 36'd0);

        set_in(10'h000, 8'h00);
        settle();
        chk("R4", "sum case A", 32'(sum_out), 32'h0A);
        chk("R5", "oe case A", 32'(oe_term), 32'h80);
        chk("R6", "ctl case A", {29'd0, preset_term, clear_term, clock_term}, 32'd1);
        chk("R9", "no stray row", 32'(sum_out[2]), 32'd0);

        // R11: input change seen before any further clock edge
        phase = "R11";
        @(posedge clk); #1;
        ded_in = 10'h21F; fb_in = 8'hA1;
        #0.5;
        chk("R11", "sum case B", 32'(sum_out), 32'h89);
        chk("R1", "oe case B", 32'(oe_term), 32'h01);
        chk("R6", "ctl case B", {29'd0, preset_term, clear_term, clock_term}, 32'd6);

        // random inputs and random writes, model compared every cycle
        phase = "R7";
        for (int i = 0; i < 300; i++) begin
            @(posedge clk); #1;
            ded_in = 10'($urandom); fb_in = 8'($urandom);
            cfg_wr = ($urandom % 4 == 0);
            cfg_row = 7'($urandom);
            cfg_bits = {4'($urandom), 32'($urandom)} & {4'($urandom), 32'($urandom)}
                       & {4'($urandom), 32'($urandom)};
        end
        @(posedge clk); #1 cfg_wr = 1'b0;

        // R8: erase wins over a simultaneous write
        phase = "R8";
        @(posedge clk); #1;
        cfg_erase = 1'b1; cfg_wr = 1'b1; cfg_row = 7'd0; cfg_bits = 36'h3;
        @(posedge clk); #1;
        cfg_erase = 1'b0; cfg_wr = 1'b0;
        settle();
        chk("R8", "sum after erase+write", 32'(sum_out), 32'hFF);
        chk("R8", "oe after erase", 32'(oe_term), 32'hFF);

        // R10: reset in the middle of a run
        phase = "R10";
        wr_row(5, 36'h3);
        for (int r = 0; r < 8; r++) wr_row(r, 36'h3);
        settle();
        chk("R10", "out0 killed before reset", 32'(sum_out[0]), 32'd0);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        settle();
        chk("R10", "sum after mid reset", 32'(sum_out), 32'hFF);

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule